// File: doc/BRIEF.md
# Vector Fetch Fault Escalation Controller

This controller models how a small processor core picks its first handler after reset. It reads handler addresses from a vector table through a synchronous read port with a request/valid handshake. The lowest bit of every fetched entry is not part of the address. Instead it selects the instruction state. Only the compact state is supported, and that state is selected by a set bit. The branch target is the entry with bit 0 cleared.

Out of reset the controller fetches the reset entry. If the entry selects the compact state, the controller presents the target PC with a one-cycle strobe and settles in a run state. If the entry requests the unsupported wide state, the controller raises an invalid-state fault. The configurable usage fault is off after reset, so this fault escalates to the hard fault, and the controller fetches the hard-fault entry. If that entry is also invalid, the fault is raised inside the hard-fault context. The controller then halts all fetching and asserts lockup, together with a sticky lockup status bit. A mode input selects a reduced variant that has no usage-fault stage: faults go straight to hard fault, which saves one cycle.

Top module: `vec_entry_ctrl`

## Requirements
- R1: While reset is held and right after it, fetch_pc is 0, handler_vld is 0, fault_cause is 0 and both lockup outputs are 0. rd_req is 1 with rd_addr = TBL_BASE + 4, which is the reset entry at word index 1.
- R2: A read request holds rd_req high and rd_addr stable through any number of cycles in which rd_valid is low. A read completes on a clock edge where rd_req and rd_valid are both high.
- R3: A reset entry with bit 0 = 1 raises handler_vld for exactly one cycle, in the cycle after the completing edge. In that cycle fetch_pc equals the entry with bit 0 cleared, and fetch_pc keeps that value afterwards. fault_cause stays 0, and no further reads are issued.
- R4: With reduced_mode = 0, a reset entry with bit 0 = 0 sets fault_cause to 1 (invalid state in the reset entry) in the cycle after the completing edge. The read of the hard-fault entry, at rd_addr = TBL_BASE + 12 (word index 3), begins one cycle later. That cycle is the usage-fault stage.
- R5: With reduced_mode = 1, the same fault sets fault_cause to 1 and starts the hard-fault read in the cycle right after the completing edge.
- R6: A hard-fault entry with bit 0 = 1 raises handler_vld for one cycle with fetch_pc equal to that entry with bit 0 cleared. fault_cause stays 1 and lockup stays 0.
- R7: A hard-fault entry with bit 0 = 0 sets fault_cause to 2 (invalid state in the hard-fault entry) in the cycle after the completing edge. In that same cycle lockup and lockup_sticky go to 1. rd_req then stays 0, and handler_vld never rises.
- R8: lockup, lockup_sticky and fault_cause hold their values until the next reset. A reset clears all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reduced_mode | input | 1 | 1 selects the variant without a usage-fault stage |
| rd_req | output | 1 | Vector read request |
| rd_addr | output | ADDR_W | Byte address of the vector being read |
| rd_valid | input | 1 | Read data valid; completes the read when rd_req is high |
| rd_data | input | ADDR_W | Vector entry returned by the table |
| fetch_pc | output | ADDR_W | Branch target with bit 0 cleared |
| handler_vld | output | 1 | One-cycle strobe: fetch_pc holds a new handler entry |
| fault_cause | output | 2 | 0 none, 1 bad reset entry, 2 bad hard-fault entry |
| lockup | output | 1 | Core halted by a fault inside the hard-fault context |
| lockup_sticky | output | 1 | Sticky lockup status, cleared only by reset |

## Verification
Each result registered by the controller appears in the cycle after the edge that completes a read. The hard-fault read request appears one cycle after the fault in reduced mode and two cycles after it in full mode. The bench models the table with a chosen number of wait cycles. From that count and the mode it works out the cycle of each completing edge, and from those the expected value of every output in every cycle. It then compares all outputs at each falling edge over the whole window.

// File: rtl/vec_pkg.sv
package vec_pkg;

    typedef enum logic [2:0] {
        ST_FETCH_RESET = 3'd0,
        ST_UF_ESC      = 3'd1,
        ST_FETCH_HF    = 3'd2,
        ST_BRANCH      = 3'd3,
        ST_RUN         = 3'd4,
        ST_LOCKUP      = 3'd5
    } ctl_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE      = 2'd0,
        CAUSE_RST_STATE = 2'd1,
        CAUSE_HF_STATE  = 2'd2
    } fault_cause_e;

endpackage

// File: rtl/vec_rd_port.sv
module vec_rd_port #(
    parameter int unsigned          ADDR_W   = 32,
    parameter logic [ADDR_W-1:0]    TBL_BASE = '0,
    parameter int unsigned          RST_IDX  = 1,
    parameter int unsigned          HF_IDX   = 3
) (
    input  logic              want_rst,
    input  logic              want_hf,
    input  logic              rd_valid,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rsp_take
);
    localparam int unsigned       WORD_BYTES = ADDR_W / 8;
    localparam logic [ADDR_W-1:0] RST_ADDR   = TBL_BASE + ADDR_W'(RST_IDX * WORD_BYTES);
    localparam logic [ADDR_W-1:0] HF_ADDR    = TBL_BASE + ADDR_W'(HF_IDX * WORD_BYTES);

    always_comb begin
        rd_req   = want_rst | want_hf;
        rd_addr  = want_hf ? HF_ADDR : RST_ADDR;
        rsp_take = rd_req & rd_valid;
    end
endmodule

// File: rtl/vec_decode.sv
module vec_decode #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] entry,
    output logic [ADDR_W-1:0] target,
    output logic              compact_ok
);
    always_comb begin
        target     = {entry[ADDR_W-1:1], 1'b0};
        compact_ok = entry[0];
    end
endmodule

// File: rtl/vec_entry_ctrl.sv
module vec_entry_ctrl
    import vec_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] TBL_BASE = 32'h0000_0100,
    parameter int unsigned       RST_IDX  = 1,
    parameter int unsigned       HF_IDX   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reduced_mode,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_data,
    output logic [ADDR_W-1:0] fetch_pc,
    output logic              handler_vld,
    output logic [1:0]        fault_cause,
    output logic              lockup,
    output logic              lockup_sticky
);
    typedef struct packed {
        ctl_state_e        state;
        logic [ADDR_W-1:0] pc;
        logic              hv;
        fault_cause_e      cause;
        logic              sticky;
    } ctl_regs_t;

    ctl_regs_t r_q, r_d;

    logic              want_rst, want_hf, rsp_take;
    logic [ADDR_W-1:0] dec_target;
    logic              dec_ok;

    assign want_rst = (r_q.state == ST_FETCH_RESET);
    assign want_hf  = (r_q.state == ST_FETCH_HF);

    vec_rd_port #(
        .ADDR_W   (ADDR_W),
        .TBL_BASE (TBL_BASE),
        .RST_IDX  (RST_IDX),
        .HF_IDX   (HF_IDX)
    ) u_port (
        .want_rst (want_rst),
        .want_hf  (want_hf),
        .rd_valid (rd_valid),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .rsp_take (rsp_take)
    );

    vec_decode #(
        .ADDR_W (ADDR_W)
    ) u_dec (
        .entry      (rd_data),
        .target     (dec_target),
        .compact_ok (dec_ok)
    );

    always_comb begin
        r_d    = r_q;
        r_d.hv = 1'b0;
        unique case (r_q.state)
            ST_FETCH_RESET: begin
                if (rsp_take) begin
                    if (dec_ok) begin
                        r_d.pc    = dec_target;
                        r_d.hv    = 1'b1;
                        r_d.state = ST_BRANCH;
                    end else begin
                        r_d.cause = CAUSE_RST_STATE;
                        r_d.state = reduced_mode ? ST_FETCH_HF : ST_UF_ESC;
                    end
                end
            end
            ST_UF_ESC: begin
                // usage fault is disabled after reset: escalate to hard fault
                r_d.state = ST_FETCH_HF;
            end
            ST_FETCH_HF: begin
                if (rsp_take) begin
                    if (dec_ok) begin
                        r_d.pc    = dec_target;
                        r_d.hv    = 1'b1;
                        r_d.state = ST_BRANCH;
                    end else begin
                        r_d.cause  = CAUSE_HF_STATE;
                        r_d.sticky = 1'b1;
                        r_d.state  = ST_LOCKUP;
                    end
                end
            end
            ST_BRANCH: r_d.state = ST_RUN;
            ST_RUN:    r_d.state = ST_RUN;
            ST_LOCKUP: r_d.state = ST_LOCKUP;
            default:   r_d.state = ST_LOCKUP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state  <= ST_FETCH_RESET;
            r_q.pc     <= '0;
            r_q.hv     <= 1'b0;
            r_q.cause  <= CAUSE_NONE;
            r_q.sticky <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign fetch_pc      = r_q.pc;
    assign handler_vld   = r_q.hv;
    assign fault_cause   = r_q.cause;
    assign lockup        = (r_q.state == ST_LOCKUP);
    assign lockup_sticky = r_q.sticky;

    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

    p_strobe_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        handler_vld |=> !handler_vld);

    p_even_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        handler_vld |-> !fetch_pc[0]);

    p_no_req_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lockup |-> (!rd_req && !handler_vld && fault_cause == 2'd2));

    p_lock_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lockup_sticky |=> (lockup_sticky && lockup));

    p_cause_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_cause != 2'd0) |=> (fault_cause != 2'd0));

endmodule

// File: tb/vec_entry_ctrl_test.sv
module vec_entry_ctrl_test;
    localparam int unsigned AW   = 32;
    localparam logic [31:0] BASE = 32'h0000_0100;
    localparam int          WIN  = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reduced_mode = 1'b0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_valid = 1'b0;
    logic [AW-1:0] rd_data = '0;
    logic [AW-1:0] fetch_pc;
    logic          handler_vld;
    logic [1:0]    fault_cause;
    logic          lockup;
    logic          lockup_sticky;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    vec_entry_ctrl #(.ADDR_W(AW), .TBL_BASE(BASE)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .reduced_mode  (reduced_mode),
        .rd_req        (rd_req),
        .rd_addr       (rd_addr),
        .rd_valid      (rd_valid),
        .rd_data       (rd_data),
        .fetch_pc      (fetch_pc),
        .handler_vld   (handler_vld),
        .fault_cause   (fault_cause),
        .lockup        (lockup),
        .lockup_sticky (lockup_sticky)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_idle(input string tag);
        check(tag, "fetch_pc", fetch_pc, 32'h0);
        check(tag, "handler_vld", {31'd0, handler_vld}, 32'd0);
        check(tag, "fault_cause", {30'd0, fault_cause}, 32'd0);
        check(tag, "lockup", {31'd0, lockup}, 32'd0);
        check(tag, "lockup_sticky", {31'd0, lockup_sticky}, 32'd0);
        check(tag, "rd_req", {31'd0, rd_req}, 32'd1);
        check(tag, "rd_addr", rd_addr, BASE + 32'd4);
    endtask

    task automatic run_case(input bit mode, input bit rv_ok, input bit hf_ok, input int wt);
        logic [31:0] rv, hv;
        int a1, f, a2, pend;
        bit   strobed;
        logic [31:0] tgt;
        rv = 32'h0000_1230 + 32'(wt * 8) + {31'd0, rv_ok};
        hv = 32'h0000_3A40 + 32'(wt * 8) + {31'd0, hf_ok};
        a1 = wt + 1;
        f  = a1 + (mode ? 0 : 1);
        a2 = f + wt + 1;
        pend = 0;
        strobed = 1'b0;
        tgt = '0;

        @(negedge clk);
        rst_n = 1'b0;
        rd_valid = 1'b0;
        reduced_mode = mode;
        @(negedge clk);
        check_idle("R1");
        check_idle("R8");
        @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < WIN; k++) begin
            bit          e_req, e_hv, e_lock;
            logic [31:0] e_addr, e_cause;
            string       t_req, t_lock;
            // table model
            if (rd_req && pend == wt) begin
                rd_valid = 1'b1;
                rd_data  = (rd_addr == BASE + 32'd4) ? rv :
                           (rd_addr == BASE + 32'd12) ? hv : 32'hDEAD_BEEF;
                pend     = 0;
            end else begin
                rd_valid = 1'b0;
                if (rd_req) pend++;
            end
            // expected schedule
            e_req = 1'b0; e_addr = '0; e_hv = 1'b0; e_lock = 1'b0; e_cause = 0;
            t_req = "R2";
            if (k < a1) begin
                e_req = 1'b1; e_addr = BASE + 32'd4;
            end else if (!rv_ok && k >= f && k < a2) begin
                e_req = 1'b1; e_addr = BASE + 32'd12;
                t_req = mode ? "R5" : "R4";
            end
            if (k >= a1 && !rv_ok && k < f) t_req = mode ? "R5" : "R4";
            if (rv_ok && k == a1) begin e_hv = 1'b1; tgt = rv & ~32'h1; strobed = 1'b1; end
            if (!rv_ok && hf_ok && k == a2) begin e_hv = 1'b1; tgt = hv & ~32'h1; strobed = 1'b1; end
            if (!rv_ok) begin
                if (k >= a2) e_cause = hf_ok ? 1 : 2;
                else if (k >= a1) e_cause = 1;
            end
            e_lock = !rv_ok && !hf_ok && k >= a2;
            if (e_lock) t_req = "R7";
            t_lock = (e_lock && k > a2) ? "R8" : "R7";

            check(t_req, "rd_req", {31'd0, rd_req}, {31'd0, e_req});
            if (e_req) check(t_req, "rd_addr", rd_addr, e_addr);
            check(rv_ok ? "R3" : "R6", "handler_vld", {31'd0, handler_vld}, {31'd0, e_hv});
            check(rv_ok ? "R3" : "R6", "fetch_pc", fetch_pc, strobed ? tgt : 32'h0);
            check(rv_ok ? "R3" : (k > a2 ? "R8" : "R4"), "fault_cause", {30'd0, fault_cause}, e_cause);
            check(t_lock, "lockup", {31'd0, lockup}, {31'd0, e_lock});
            check(t_lock, "lockup_sticky", {31'd0, lockup_sticky}, {31'd0, e_lock});
            @(negedge clk);
        end
        rd_valid = 1'b0;
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int m = 0; m < 2; m++)
            for (int r = 0; r < 2; r++)
                for (int h = 0; h < 2; h++)
                    for (int w = 0; w < 4; w++)
                        run_case(m[0], r[0], h[0], w);
        // a reset taken while locked up clears everything (R8)
        run_case(1'b0, 1'b0, 1'b0, 2);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle("R8");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule